// File: doc/BRIEF.md
# Port Burst Address Counter

This block generates the word address that one port of a synchronous memory presents to its array. Each clock it either takes a 12-bit address from outside or makes one from an internal counter. The counter can be cleared to zero, loaded, held or advanced by one. Three active-low controls choose the action, and a fixed priority settles any conflict between them. A caller can start a burst by strobing in a start address and then step through the words that follow with the count enable alone. The external address bus does not need to be driven during the burst.

The address used in a cycle is formed combinationally from the controls, the external address and the counter. The counter register captures that address on the rising edge, so the next cycle continues from it. A load therefore reaches the array in the cycle in which it is strobed. A clear reaches the array as address 0 in its own cycle, with no idle cycle inserted. The block has no data path and no stream interface. All pins are plain control and address signals.

Top module: `burst_addr_gen`

## Requirements
- R1: After the block reset `rst_n` (active low) is released, and while all three controls are high, `addr_out` is 0.
- R2: When `zero_n` is low, `addr_out` is 0 in that same cycle. The counter then continues from 0, so an increment in the next cycle gives 1.
- R3: `zero_n` low takes priority over `strobe_n` low and over `step_n` low.
- R4: When `strobe_n` is low and `zero_n` is high, `addr_out` equals `ext_addr` in that same cycle.
- R5: After a load, the counter continues from the loaded value. A following hold cycle gives that value, and a following increment cycle gives that value plus one.
- R6: `strobe_n` low takes priority over `step_n` low.
- R7: When all three controls are high, `addr_out` keeps its previous value and changes in `ext_addr` have no effect.
- R8: When `step_n` is low and both `zero_n` and `strobe_n` are high, `addr_out` is the previous cycle's address plus one.
- R9: An increment from 4095, the largest 12-bit address, gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Block reset, active low, clears the counter to 0 |
| ext_addr | input | 12 | External address, used on load cycles |
| strobe_n | input | 1 | Load request, active low |
| step_n | input | 1 | Count enable, active low |
| zero_n | input | 1 | Counter clear request, active low |
| addr_out | output | 12 | Address used by the array in this cycle |

## Verification
A clear, a load and an increment can all be requested in the same cycle. The bench provokes this by driving two or three controls low together in both directed and random cycles. Each cycle it compares `addr_out` against a behavioural model that applies the priority clear, then load, then increment, and it checks the same cycle for a clear or a load and the next cycle for the continuation. Walking across 4095 with a load followed by increments shows that the counter wraps.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_ZERO = 2'd3
  } act_e;
endpackage

// File: rtl/burst_act_decode.sv
module burst_act_decode
  import burst_addr_pkg::*;
(
  input  logic zero_n,
  input  logic strobe_n,
  input  logic step_n,
  output act_e act
);
  // fixed priority: clear, load, increment, hold
  always_comb begin
    if (!zero_n)        act = ACT_ZERO;
    else if (!strobe_n) act = ACT_LOAD;
    else if (!step_n)   act = ACT_STEP;
    else                act = ACT_HOLD;
  end
endmodule

// File: rtl/burst_addr_sel.sv
module burst_addr_sel
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  act_e              act,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] use_addr
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    unique case (act)
      ACT_ZERO: use_addr = '0;
      ACT_LOAD: use_addr = ext_addr;
      ACT_STEP: use_addr = cur + ONE;  // wraps naturally at the top
      default:  use_addr = cur;
    endcase
  end
endmodule

// File: rtl/burst_cnt_reg.sv
module burst_cnt_reg #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_n,
  input  logic              step_n,
  input  logic              zero_n,
  output logic [ADDR_W-1:0] addr_out
);
  act_e              act;
  logic [ADDR_W-1:0] cnt_q;
  logic [ADDR_W-1:0] use_addr;
  logic              live;

  burst_act_decode u_dec (
    .zero_n   (zero_n),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .act      (act)
  );

  burst_addr_sel #(.ADDR_W(ADDR_W)) u_sel (
    .act      (act),
    .ext_addr (ext_addr),
    .cur      (cnt_q),
    .use_addr (use_addr)
  );

  burst_cnt_reg #(.ADDR_W(ADDR_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (use_addr),
    .q     (cnt_q)
  );

  assign addr_out = use_addr;

  // marks cycles whose previous cycle was out of reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  // R2
  zero_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |-> addr_out == '0);

  // R2
  zero_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |=> (!(zero_n && strobe_n && step_n) || addr_out == '0));

  // R4
  load_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && !strobe_n) |-> addr_out == ext_addr);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && zero_n && strobe_n && step_n) |-> $stable(addr_out));

  // R8
  step_plus_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && zero_n && strobe_n && !step_n) |->
      addr_out == ADDR_W'($past(addr_out) + ADDR_W'(1)));
endmodule

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ext_addr = '0;
  logic        strobe_n = 1'b1;
  logic        step_n = 1'b1;
  logic        zero_n = 1'b1;
  logic [11:0] addr_out;

  int runs = 0;
  int fails = 0;
  int model = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_addr (ext_addr),
    .strobe_n (strobe_n),
    .step_n   (step_n),
    .zero_n   (zero_n),
    .addr_out (addr_out)
  );

  task automatic check(input string tag, input int exp);
    runs++;
    if (int'(addr_out) != exp) begin
      fails++;
      $display("FAIL %s: addr_out=%0d expected=%0d", tag, addr_out, exp);
    end
  endtask

  // one clock: drive at the falling edge, check mid-cycle, advance model at the rising edge
  task automatic cyc(input bit z, input bit s, input bit t, input int ea, input string tag);
    int exp;
    @(negedge clk);
    zero_n = z; strobe_n = s; step_n = t; ext_addr = 12'(ea);
    #1;
    if (!z)      exp = 0;
    else if (!s) exp = ea % 4096;
    else if (!t) exp = (model + 1) % 4096;
    else         exp = model;
    check(tag, exp);
    @(posedge clk);
    model = exp;
  endtask

  initial begin
    #200000;
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog: expired expected=finish");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", 0);
    cyc(1, 1, 1, 1234, "R1");
    cyc(1, 1, 0, 0, "R8");
    cyc(1, 1, 0, 0, "R8");
    cyc(1, 1, 1, 3000, "R7");
    cyc(1, 1, 1, 77, "R7");
    cyc(1, 0, 1, 500, "R4");
    cyc(1, 1, 1, 9, "R5");
    cyc(1, 1, 0, 9, "R5");
    cyc(1, 0, 0, 800, "R6");
    cyc(1, 1, 0, 0, "R8");
    cyc(0, 1, 1, 0, "R2");
    cyc(1, 1, 0, 0, "R2");
    cyc(0, 0, 0, 2222, "R3");
    cyc(0, 0, 1, 1111, "R3");
    cyc(0, 1, 0, 0, "R3");
    cyc(1, 0, 1, 4094, "R4");
    cyc(1, 1, 0, 0, "R8");
    cyc(1, 1, 0, 0, "R9");
    cyc(1, 1, 0, 0, "R9");
    cyc(1, 0, 0, 4095, "R6");
    cyc(1, 1, 1, 0, "R7");
    cyc(1, 1, 0, 0, "R9");
    for (int i = 0; i < 400; i++) begin
      bit z, s, t;
      int ea;
      z = ($urandom % 6) != 0;
      s = ($urandom % 4) != 0;
      t = ($urandom % 2) != 0;
      ea = $urandom % 4096;
      if (!z)      cyc(z, s, t, ea, "R3");
      else if (!s) cyc(z, s, t, ea, "R6");
      else if (!t) cyc(z, s, t, ea, "R8");
      else         cyc(z, s, t, ea, "R7");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule